// File: doc/BRIEF.md
# Dual Halfword Signed Multiply-Accumulate Unit

This unit treats each of its two 32-bit multiplicand operands as a pair of signed 16-bit halfwords. It multiplies the low halves together and the high halves together. It then combines the two products by addition or subtraction and, when asked, adds a 32-bit signed accumulator operand. The low 32 bits of the exact result are registered as the output word. A sticky saturation flag records whether that exact result would not fit in a signed 32-bit word.

Overflow is judged only once, on the complete sum. The unit never checks a partial sum. A case where the two products overflow on their own but the accumulator brings the total back into range therefore leaves the flag untouched. An operation is issued by raising `inValid` for one cycle. The result appears one clock later with `outValid`. The flag can be cleared synchronously at any time.

Top module: `dual_mac_unit`

## Requirements
- R1: Lane 0 multiplies `opA[15:0]` by `opB[15:0]` and lane 1 multiplies `opA[31:16]` by `opB[31:16]`, both as two's-complement signed 16-bit values.
- R2: When `swapHalves`=1, the two halfwords of `opB` are exchanged before multiplication, so lane 0 uses `opB[31:16]` and lane 1 uses `opB[15:0]`.
- R3: With `subMode`=0 and `accEn`=1, `result` is the low 32 bits of lane0 + lane1 + signed `opC`, computed exactly.
- R4: `satFlag` is set when the exact sum lies outside the signed 32-bit range. No intermediate partial sum is checked. Example: opA=opB=0x80008000 and opC=0xFFFFFFFF in add-accumulate mode give result 0x7FFFFFFF and leave `satFlag` unchanged.
- R5: With `accEn`=0, `opC` has no effect. In that case `result` is lane0 ± lane1, and in add mode `satFlag` is set on signed 32-bit overflow of that sum.
- R6: With `subMode`=1, `result` is lane0 − lane1, plus `opC` when `accEn`=1. Subtraction without accumulation never sets `satFlag`.
- R7: `satFlag` is sticky: an operation can only set it, and it keeps its value when the operation does not overflow.
- R8: `qClear`=1 clears `satFlag` at the next clock edge. The clear takes priority over a set from an operation issued in the same cycle.
- R9: `result` and `outValid`=1 appear at the clock edge after `inValid`=1. When `inValid`=0, `outValid` drops to 0, `result` holds, and `satFlag` is unaffected by the operands.
- R10: While `rstN`=0, `result`, `outValid` and `satFlag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Issue an operation this cycle |
| subMode | input | 1 | 1: subtract lane 1 from lane 0; 0: add |
| swapHalves | input | 1 | Exchange halfwords of opB before multiplying |
| accEn | input | 1 | Add opC to the product combination |
| qClear | input | 1 | Synchronous clear of the saturation flag |
| opA | input | 32 | First multiplicand pair |
| opB | input | 32 | Second multiplicand pair |
| opC | input | 32 | Signed accumulator operand |
| outValid | output | 1 | Result registered from the previous cycle's issue |
| result | output | 32 | Low 32 bits of the exact result |
| satFlag | output | 1 | Sticky signed-overflow flag |

## Verification
Directed operands with small distinct halfwords separate lane 0 from lane 1, so they expose swapped or mismatched halfword pairing, with and without `swapHalves`. Operands built from 0x8000, 0x7FFF, 0x0000 and 0xFFFF halfwords are run through all four mode combinations. They probe the −32768 × −32768 product and the case where the accumulator cancels an overflow of the products. This separates a single exact overflow test from a two-step test. Random operands, with occasional clears in the same cycle, compare the result and the sticky flag against a 64-bit model. Idle cycles carrying overflowing operands show that nothing changes without an issue.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic load;    // capture result and evaluate overflow
    logic clearQ;  // clear the sticky flag
  } strobe_t;

endpackage

// File: rtl/dmac_ctrl.sv
module dmac_ctrl (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              qClear,
  output dmac_pkg::strobe_t stb,
  output logic              outValid
);

  always_comb begin
    stb.load   = inValid;
    stb.clearQ = qClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R9: valid follows issue by one cycle
  a_r9_valid_follow: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r9_valid_drop: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/dmac_datapath.sv
module dmac_datapath #(
  parameter int HALF_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dmac_pkg::strobe_t      stb,
  input  logic                   subMode,
  input  logic                   swapHalves,
  input  logic                   accEn,
  input  logic [2*HALF_W-1:0]    opA,
  input  logic [2*HALF_W-1:0]    opB,
  input  logic [2*HALF_W-1:0]    opC,
  output logic [2*HALF_W-1:0]    result,
  output logic                   satFlag
);

  localparam int WORD_W = 2 * HALF_W;
  localparam int SUM_W  = WORD_W + 2;
  localparam int LANES  = 2;

  logic [WORD_W-1:0]        bSel;
  logic signed [WORD_W-1:0] prod [LANES];

  assign bSel = swapHalves ? {opB[HALF_W-1:0], opB[WORD_W-1:HALF_W]} : opB;

  // One signed halfword multiplier per lane; the product always fits WORD_W.
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic signed [HALF_W-1:0] aH;
    logic signed [HALF_W-1:0] bH;
    assign aH = opA[g*HALF_W +: HALF_W];
    assign bH = bSel[g*HALF_W +: HALF_W];
    assign prod[g] = WORD_W'(aH) * WORD_W'(bH);
  end

  // Exact three-term sum; overflow judged once on the whole value.
  logic signed [SUM_W-1:0] p0x, p1x, cx, exact;
  logic                    ovf;

  always_comb begin
    p0x   = SUM_W'(prod[0]);
    p1x   = SUM_W'(prod[1]);
    cx    = accEn ? SUM_W'($signed(opC)) : '0;
    exact = subMode ? (p0x - p1x + cx) : (p0x + p1x + cx);
    ovf   = !((&exact[SUM_W-1:WORD_W-1]) || !(|exact[SUM_W-1:WORD_W-1]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         result <= '0;
    else if (stb.load) result <= exact[WORD_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                satFlag <= 1'b0;
    else if (stb.clearQ)      satFlag <= 1'b0;
    else if (stb.load && ovf) satFlag <= 1'b1;
  end

  // R7: once set, the flag stays until a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (satFlag && !stb.clearQ) |=> satFlag);
  // R8: clear wins
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearQ |=> !satFlag);
  // R9: no issue, no change
  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(result));
  a_r9_hold_flag: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && !stb.clearQ) |=> $stable(satFlag));
  // R6: subtract without accumulate cannot overflow
  a_r6_sub_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && subMode && !accEn && !satFlag && !stb.clearQ) |=> !satFlag);

endmodule

// File: rtl/dual_mac_unit.sv
module dual_mac_unit #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                subMode,
  input  logic                swapHalves,
  input  logic                accEn,
  input  logic                qClear,
  input  logic [2*HALF_W-1:0] opA,
  input  logic [2*HALF_W-1:0] opB,
  input  logic [2*HALF_W-1:0] opC,
  output logic                outValid,
  output logic [2*HALF_W-1:0] result,
  output logic                satFlag
);

  dmac_pkg::strobe_t stb;

  dmac_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .qClear   (qClear),
    .stb      (stb),
    .outValid (outValid)
  );

  dmac_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .subMode    (subMode),
    .swapHalves (swapHalves),
    .accEn      (accEn),
    .opA        (opA),
    .opB        (opB),
    .opC        (opC),
    .result     (result),
    .satFlag    (satFlag)
  );

endmodule

// File: tb/sim_dual_mac_unit.sv
module sim_dual_mac_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, subMode = 1'b0, swapHalves = 1'b0, accEn = 1'b0, qClear = 1'b0;
  logic [31:0] opA = '0, opB = '0, opC = '0;
  logic        outValid, satFlag;
  logic [31:0] result;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic qModel = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dual_mac_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .subMode(subMode),
    .swapHalves(swapHalves), .accEn(accEn), .qClear(qClear),
    .opA(opA), .opB(opB), .opC(opC),
    .outValid(outValid), .result(result), .satFlag(satFlag)
  );

  function automatic longint exactOf(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                                     bit sub, bit swp, bit acc);
    logic [31:0] bb;
    longint p0, p1, s;
    bb = swp ? {b[15:0], b[31:16]} : b;
    p0 = longint'($signed(a[15:0]))  * longint'($signed(bb[15:0]));
    p1 = longint'($signed(a[31:16])) * longint'($signed(bb[31:16]));
    s  = sub ? p0 - p1 : p0 + p1;
    if (acc) s = s + longint'($signed(c));
    return s;
  endfunction

  function automatic bit overflows(longint s);
    return s != longint'($signed(s[31:0]));
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Issue one operation, then sample just after the capturing edge.
  task automatic doOp(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                      bit sub, bit swp, bit acc, bit clr);
    longint s;
    string rTag;
    @(negedge clk);
    opA = a; opB = b; opC = c; subMode = sub; swapHalves = swp; accEn = acc;
    qClear = clr; inValid = 1'b1;
    s = exactOf(a, b, c, sub, swp, acc);
    qModel = clr ? 1'b0 : (qModel | overflows(s));
    @(posedge clk); #1;
    rTag = sub ? "R6" : (acc ? "R3" : "R5");
    check(rTag, result, s[31:0]);
    check(clr ? "R8" : "R7", {31'b0, satFlag}, {31'b0, qModel});
    check("R9", {31'b0, outValid}, 32'd1);
    @(negedge clk);
    inValid = 1'b0; qClear = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] cor [4];
    logic [31:0] hold;
    cor[0] = 16'h8000; cor[1] = 16'h7FFF; cor[2] = 16'h0000; cor[3] = 16'hFFFF;
    void'($urandom(32'd1357));

    repeat (3) @(posedge clk);
    #1;
    check("R10", result, 32'd0);
    check("R10", {31'b0, satFlag}, 32'd0);
    check("R10", {31'b0, outValid}, 32'd0);
    @(negedge clk); rstN = 1'b1;

    // R1 lane pairing, R2 swap
    doOp(32'h0002_0003, 32'h0005_0007, 32'h0, 0, 0, 0, 0);
    check("R1", result, 32'd31);
    doOp(32'h0002_0003, 32'h0005_0007, 32'h0, 0, 1, 0, 0);
    check("R2", result, 32'd29);
    // R5: opC ignored when accumulate off
    doOp(32'h0002_0003, 32'h0005_0007, 32'h1234_5678, 0, 0, 0, 0);
    check("R5", result, 32'd31);

    // R4: products overflow alone, accumulator cancels
    doOp(32'h8000_8000, 32'h8000_8000, 32'hFFFF_FFFF, 0, 0, 1, 0);
    check("R4", result, 32'h7FFF_FFFF);
    check("R4", {31'b0, satFlag}, 32'd0);
    // R5: same products without accumulate overflow
    doOp(32'h8000_8000, 32'h8000_8000, 32'h0, 0, 0, 0, 0);
    check("R5", {31'b0, satFlag}, 32'd1);
    // R7: non-overflowing op keeps flag
    doOp(32'h0001_0001, 32'h0001_0001, 32'h0, 0, 0, 1, 0);
    check("R7", {31'b0, satFlag}, 32'd1);
    // R8: clear with overflowing op in same cycle
    doOp(32'h8000_8000, 32'h8000_8000, 32'h0, 0, 0, 0, 1);
    check("R8", {31'b0, satFlag}, 32'd0);
    // R6: subtract without accumulate, extreme lanes, never sets
    doOp(32'h8000_8000, 32'h8000_7FFF, 32'h0, 1, 0, 0, 0);
    check("R6", {31'b0, satFlag}, 32'd0);
    // R6: subtract with accumulate overflows
    doOp(32'h0000_8000, 32'h0000_8000, 32'h7FFF_FFFF, 1, 0, 1, 0);
    check("R6", {31'b0, satFlag}, 32'd1);

    // R9: idle cycle with overflowing operands changes nothing
    hold = result;
    @(negedge clk);
    opA = 32'h8000_8000; opB = 32'h8000_8000; opC = 32'h7FFF_FFFF;
    subMode = 0; accEn = 1; inValid = 0;
    doIdleCheck(hold);
    qModel = 1'b1;
    doOp(32'h0, 32'h0, 32'h0, 0, 0, 0, 1);  // clear for next phase

    // Corner halfwords in all mode combinations
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int m = 0; m < 4; m++)
          doOp({cor[i], cor[j]}, {cor[j], cor[i]}, {cor[(i+j)%4], cor[(i+m)%4]},
               m[1], 1'b0, m[0], (m == 0));

    // Random
    for (int k = 0; k < 300; k++)
      doOp($urandom, $urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom % 5) == 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic doIdleCheck(logic [31:0] hold);
    @(posedge clk); #1;
    check("R9", result, hold);
    check("R9", {31'b0, outValid}, 32'd0);
    check("R9", {31'b0, satFlag}, 32'd1);
  endtask

endmodule